// File: doc/BRIEF.md
# Call Gate Stack Switch Sequencer

This block carries out the stack traffic of a far call made through a call gate, once the descriptors behind the call have been checked. On a start strobe it captures the whole request. It checks the target offset against the code segment limit. It checks that the stack that will receive the pushes has enough room. It then issues one memory request per cycle on a simple port: writes for pushes, and reads that fetch caller parameters.

When the call raises privilege, the block moves to the new stack given by the task state. It saves the caller's stack pointer there, copies the caller's parameters across and then pushes the return address. A call at the same privilege pushes only the return address onto the current stack. On completion it updates the SS, ESP, CS, EIP and CPL outputs together and raises a one-cycle done flag. A failed check instead raises a one-cycle fault flag, makes no request and leaves those outputs untouched.

Top module: `cg_stack_seq`

## Requirements
- R1: Under reset (synchronous, active low) SS, ESP, CS and EIP read zero, CPL reads the parameter RESET_CPL (default 3), and done, both fault flags and the memory request are low.
- R2: The parameter count is the low 5 bits of the gate word-count input (0 to 31); higher bits have no effect.
- R3: For a privilege raise with 32-bit operands the sequence proceeds only if new ESP >= new floor + 4*count + 16; otherwise the stack fault flag pulses.
- R4: For a privilege raise with 16-bit operands the sequence proceeds only if new ESP >= new floor + 2*count + 8; otherwise the stack fault flag pulses.
- R5: On a privilege raise every write goes to the new SS at addresses falling from new ESP by the push size. The writes come in this order: old SS, old ESP, the parameters, return CS, return EIP.
- R6: Parameters are copied oldest first. Reads go to the old SS at old ESP + (count-1-i)*size for i = 0 up. Each read is followed in the next cycle by a write of the returned data.
- R7: With 32-bit operands every push is 4 bytes wide, and selectors are zero-extended to 32 bits, so a return address takes 8 bytes. With 16-bit operands every push is 2 bytes and carries the low 16 bits.
- R8: A same-privilege call pushes only return CS and return EIP on the old stack. It needs old ESP >= old floor + 8 (32-bit) or + 4 (16-bit), else the stack fault flag pulses. The parameter count has no effect.
- R9: The effective target offset is the full EIP for 32-bit operands and its low 16 bits for 16-bit operands. If it exceeds the code limit, the general fault flag pulses with no memory request. This check takes priority over the room check.
- R10: In the cycle after the last push, done is high for one cycle. ESP holds the last push address, SS holds the stack used and EIP holds the effective target. CS holds the target selector with its low 2 bits replaced by the new CPL. CPL becomes the new stack DPL on a raise and is unchanged otherwise.
- R11: On a fault the flag is high for exactly one cycle, SS, ESP, CS, EIP and CPL keep their values, and the block accepts a new start afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle |
| raise_i | input | 1 | 1 = privilege raise, 0 = same privilege |
| op32_i | input | 1 | 1 = 32-bit operand size |
| word_cnt_i | input | 8 | Gate word-count field |
| old_ss_i | input | 16 | Caller stack selector |
| old_esp_i | input | 32 | Caller stack pointer |
| old_floor_i | input | 32 | Lowest usable address of caller stack |
| new_ss_i | input | 16 | Stack selector from task state |
| new_esp_i | input | 32 | Stack pointer from task state |
| new_floor_i | input | 32 | Lowest usable address of new stack |
| new_dpl_i | input | 2 | DPL of the new stack segment |
| tgt_cs_i | input | 16 | Target code selector from the gate |
| tgt_eip_i | input | 32 | Target offset from the gate |
| cs_limit_i | input | 32 | Target code segment limit |
| ret_cs_i | input | 16 | Return selector |
| ret_eip_i | input | 32 | Return offset |
| mem_req_o | output | 1 | Memory request this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wide_o | output | 1 | 1 = 4-byte access, 0 = 2-byte |
| mem_seg_o | output | 16 | Selector of the accessed stack |
| mem_addr_o | output | 32 | Offset of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read |
| done_o | output | 1 | Completion pulse |
| fault_gp_o | output | 1 | Target offset fault pulse |
| fault_ss_o | output | 1 | Stack room fault pulse |
| ss_o | output | 16 | Resulting SS |
| esp_o | output | 32 | Resulting ESP |
| cs_o | output | 16 | Resulting CS |
| eip_o | output | 32 | Resulting EIP |
| cpl_o | output | 2 | Resulting CPL |

## Verification
The assertions assume that memory returns read data exactly one cycle after the read and never stalls. They also assume that floor plus the required room does not wrap past the top of the 32-bit offset space, so push addresses fall monotonically. The bench models memory as a registered lookup of a pattern derived from the address. It keeps every floor and stack pointer small, so the room sums never approach the wrap point.

// File: rtl/cgs_pkg.sv
// Shared widths, state encoding and captured request for the call gate
// stack sequencer. Assumes 16-bit selectors and 32-bit offsets.
package cgs_pkg;
    localparam int SEL_W = 16;
    localparam int OFS_W = 32;
    localparam int CNT_W = 5;
    localparam int WC_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CHK, ST_PSS, ST_PSP, ST_RD, ST_WR, ST_PCS, ST_PIP, ST_DONE
    } cgs_state_e;

    typedef struct packed {
        logic             raise;
        logic             op32;
        logic [CNT_W-1:0] nparm;
        logic [SEL_W-1:0] old_ss;
        logic [OFS_W-1:0] old_esp;
        logic [OFS_W-1:0] old_floor;
        logic [SEL_W-1:0] new_ss;
        logic [OFS_W-1:0] new_esp;
        logic [OFS_W-1:0] new_floor;
        logic [1:0]       new_dpl;
        logic [SEL_W-1:0] tgt_cs;
        logic [OFS_W-1:0] tgt_eip;
        logic [OFS_W-1:0] cs_limit;
        logic [SEL_W-1:0] ret_cs;
        logic [OFS_W-1:0] ret_eip;
    } cgs_req_t;
endpackage

// File: rtl/cgs_room_check.sv
// Decides whether the selected stack can take every push of the call.
// Pure combinational; assumes floor + need does not exceed OW+1 bits.
module cgs_room_check #(
    parameter int OW = 32,
    parameter int CW = 5
) (
    input  logic          raise,
    input  logic          op32,
    input  logic [CW-1:0] nparm,
    input  logic [OW-1:0] esp,
    input  logic [OW-1:0] floor_ofs,
    output logic          fits
);
    logic [OW:0] need;
    logic [OW:0] lowest;

    // Size-dependent overhead plus parameter bytes, compared with headroom.
    always_comb begin
        if (raise)
            need = ((OW+1)'(nparm) << (op32 ? 2 : 1)) + (op32 ? (OW+1)'(16) : (OW+1)'(8));
        else
            need = op32 ? (OW+1)'(8) : (OW+1)'(4);
        lowest = {1'b0, floor_ofs} + need;
        fits   = {1'b0, esp} >= lowest;
    end
endmodule

// File: rtl/cgs_param_walk.sv
// Tracks how many parameters remain and where the next oldest one lies
// on the caller stack. Assumes step is only pulsed while count is nonzero.
module cgs_param_walk #(
    parameter int OW = 32,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          op32,
    input  logic [CW-1:0] nparm,
    input  logic [OW-1:0] base,
    output logic [OW-1:0] rd_addr,
    output logic          none,
    output logic          last
);
    logic [CW-1:0] rem_q;
    logic [OW-1:0] ptr_q;
    logic [OW-1:0] psz;

    assign psz     = op32 ? OW'(4) : OW'(2);
    assign rd_addr = ptr_q;
    assign none    = (rem_q == '0);
    assign last    = (rem_q == CW'(1));

    // Load start point at the oldest parameter, then walk toward old ESP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            ptr_q <= '0;
        end else if (load) begin
            rem_q <= nparm;
            ptr_q <= base + (OW'(nparm) << (op32 ? 2 : 1)) - psz;
        end else if (step) begin
            rem_q <= rem_q - CW'(1);
            ptr_q <= ptr_q - psz;
        end
    end

    AST_WALK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !none); // R2
endmodule

// File: rtl/cg_stack_seq.sv
// Sequencer for the stack traffic of a call through a call gate. Captures
// the request, checks target limit and stack room, then issues one memory
// access per cycle. Assumes memory answers reads one cycle later.
module cg_stack_seq
    import cgs_pkg::*;
#(
    parameter logic [1:0] RESET_CPL = 2'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             raise_i,
    input  logic             op32_i,
    input  logic [WC_W-1:0]  word_cnt_i,
    input  logic [SEL_W-1:0] old_ss_i,
    input  logic [OFS_W-1:0] old_esp_i,
    input  logic [OFS_W-1:0] old_floor_i,
    input  logic [SEL_W-1:0] new_ss_i,
    input  logic [OFS_W-1:0] new_esp_i,
    input  logic [OFS_W-1:0] new_floor_i,
    input  logic [1:0]       new_dpl_i,
    input  logic [SEL_W-1:0] tgt_cs_i,
    input  logic [OFS_W-1:0] tgt_eip_i,
    input  logic [OFS_W-1:0] cs_limit_i,
    input  logic [SEL_W-1:0] ret_cs_i,
    input  logic [OFS_W-1:0] ret_eip_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic             mem_wide_o,
    output logic [SEL_W-1:0] mem_seg_o,
    output logic [OFS_W-1:0] mem_addr_o,
    output logic [OFS_W-1:0] mem_wdata_o,
    input  logic [OFS_W-1:0] mem_rdata_i,
    output logic             done_o,
    output logic             fault_gp_o,
    output logic             fault_ss_o,
    output logic [SEL_W-1:0] ss_o,
    output logic [OFS_W-1:0] esp_o,
    output logic [SEL_W-1:0] cs_o,
    output logic [OFS_W-1:0] eip_o,
    output logic [1:0]       cpl_o
);
    localparam int HALF = OFS_W / 2;

    cgs_state_e       state_q;
    cgs_req_t         rq;
    logic [OFS_W-1:0] sp_q;
    logic [OFS_W-1:0] psz, push_addr, tgt_eff, stk_esp, stk_floor, walk_addr;
    logic [SEL_W-1:0] stk_ss;
    logic             fits, gp_bad, walk_none, walk_last;
    logic [1:0]       cpl_next;

    // Derived quantities of the captured request.
    always_comb begin
        psz       = rq.op32 ? OFS_W'(4) : OFS_W'(2);
        push_addr = sp_q - psz;
        tgt_eff   = rq.op32 ? rq.tgt_eip : {{HALF{1'b0}}, rq.tgt_eip[HALF-1:0]};
        gp_bad    = tgt_eff > rq.cs_limit;
        stk_ss    = rq.raise ? rq.new_ss    : rq.old_ss;
        stk_esp   = rq.raise ? rq.new_esp   : rq.old_esp;
        stk_floor = rq.raise ? rq.new_floor : rq.old_floor;
        cpl_next  = rq.raise ? rq.new_dpl   : cpl_o;
    end

    cgs_room_check #(.OW(OFS_W), .CW(CNT_W)) u_room (
        .raise(rq.raise), .op32(rq.op32), .nparm(rq.nparm),
        .esp(stk_esp), .floor_ofs(stk_floor), .fits(fits)
    );

    cgs_param_walk #(.OW(OFS_W), .CW(CNT_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_CHK), .step(state_q == ST_WR),
        .op32(rq.op32), .nparm(rq.nparm), .base(rq.old_esp),
        .rd_addr(walk_addr), .none(walk_none), .last(walk_last)
    );

    // Memory port drive for the current state.
    always_comb begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wide_o  = rq.op32;
        mem_seg_o   = stk_ss;
        mem_addr_o  = push_addr;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_PSS: mem_wdata_o = OFS_W'(rq.old_ss);
            ST_PSP: mem_wdata_o = rq.op32 ? rq.old_esp : OFS_W'(rq.old_esp[HALF-1:0]);
            ST_RD: begin
                mem_we_o   = 1'b0;
                mem_seg_o  = rq.old_ss;
                mem_addr_o = walk_addr;
            end
            ST_WR:  mem_wdata_o = rq.op32 ? mem_rdata_i : OFS_W'(mem_rdata_i[HALF-1:0]);
            ST_PCS: mem_wdata_o = OFS_W'(rq.ret_cs);
            ST_PIP: mem_wdata_o = rq.op32 ? rq.ret_eip : OFS_W'(rq.ret_eip[HALF-1:0]);
            default: begin
                mem_req_o = 1'b0;
                mem_we_o  = 1'b0;
            end
        endcase
    end

    assign done_o = (state_q == ST_DONE);

    // Sequence control, stack pointer walk and architectural update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rq         <= '0;
            sp_q       <= '0;
            fault_gp_o <= 1'b0;
            fault_ss_o <= 1'b0;
            ss_o       <= '0;
            esp_o      <= '0;
            cs_o       <= '0;
            eip_o      <= '0;
            cpl_o      <= RESET_CPL;
        end else begin
            fault_gp_o <= 1'b0;
            fault_ss_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    rq <= '{raise: raise_i, op32: op32_i, nparm: word_cnt_i[CNT_W-1:0],
                            old_ss: old_ss_i, old_esp: old_esp_i, old_floor: old_floor_i,
                            new_ss: new_ss_i, new_esp: new_esp_i, new_floor: new_floor_i,
                            new_dpl: new_dpl_i, tgt_cs: tgt_cs_i, tgt_eip: tgt_eip_i,
                            cs_limit: cs_limit_i, ret_cs: ret_cs_i, ret_eip: ret_eip_i};
                    state_q <= ST_CHK;
                end
                ST_CHK: begin
                    sp_q <= stk_esp;
                    if (gp_bad) begin
                        fault_gp_o <= 1'b1;
                        state_q    <= ST_IDLE;
                    end else if (!fits) begin
                        fault_ss_o <= 1'b1;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q <= rq.raise ? ST_PSS : ST_PCS;
                    end
                end
                ST_PSS: begin
                    sp_q    <= push_addr;
                    state_q <= ST_PSP;
                end
                ST_PSP: begin
                    sp_q    <= push_addr;
                    state_q <= walk_none ? ST_PCS : ST_RD;
                end
                ST_RD: state_q <= ST_WR;
                ST_WR: begin
                    sp_q    <= push_addr;
                    state_q <= walk_last ? ST_PCS : ST_RD;
                end
                ST_PCS: begin
                    sp_q    <= push_addr;
                    state_q <= ST_PIP;
                end
                ST_PIP: begin
                    sp_q    <= push_addr;
                    ss_o    <= stk_ss;
                    esp_o   <= push_addr;
                    eip_o   <= tgt_eff;
                    cpl_o   <= cpl_next;
                    cs_o    <= {rq.tgt_cs[SEL_W-1:2], cpl_next};
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_NO_WRITE_BELOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_addr_o >= stk_floor)); // R3
    AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o)) |-> (mem_addr_o < $past(mem_addr_o))); // R5
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o)); // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_gp_o, fault_ss_o})); // R9
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp_o || fault_ss_o) |-> !mem_req_o); // R11
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp_o || fault_ss_o) |=> !(fault_gp_o || fault_ss_o)); // R11
    AST_ARCH_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ss_o, esp_o, cs_o, eip_o, cpl_o}) |-> done_o); // R10
endmodule

// File: tb/cg_stack_seq_bench.sv
// Directed bench: each task sets up one call, logs the memory traffic and
// compares traffic and results against values computed here.
module cg_stack_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, raise = 1'b0, op32 = 1'b0;
    logic [7:0]  wcnt = '0;
    logic [15:0] oss = '0, nss = '0, tcs = '0, rcs = '0;
    logic [31:0] oesp = '0, oflr = '0, nesp = '0, nflr = '0, teip = '0, clim = '0, reip = '0;
    logic [1:0]  ndpl = '0;
    logic        req, we, wide, done, fgp, fss;
    logic [15:0] seg, ss, cs;
    logic [31:0] addr, wdata, esp, eip;
    logic [31:0] rdata = '0;
    logic [1:0]  cpl;

    int n_chk = 0, n_bad = 0;
    logic [1:0] exp_cpl = 2'd3;

    // Logged and expected traffic.
    logic        l_we[64], e_we[64];
    logic [15:0] l_seg[64], e_seg[64];
    logic [31:0] l_addr[64], e_addr[64], l_dat[64], e_dat[64];
    logic        l_wide[64];
    int          l_n, e_n;
    logic        saw_done, saw_gp, saw_ss;

    always #10 clk = ~clk;

    cg_stack_seq u_cg_stack_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .raise_i(raise), .op32_i(op32),
        .word_cnt_i(wcnt), .old_ss_i(oss), .old_esp_i(oesp), .old_floor_i(oflr),
        .new_ss_i(nss), .new_esp_i(nesp), .new_floor_i(nflr), .new_dpl_i(ndpl),
        .tgt_cs_i(tcs), .tgt_eip_i(teip), .cs_limit_i(clim), .ret_cs_i(rcs),
        .ret_eip_i(reip), .mem_req_o(req), .mem_we_o(we), .mem_wide_o(wide),
        .mem_seg_o(seg), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
        .done_o(done), .fault_gp_o(fgp), .fault_ss_o(fss), .ss_o(ss), .esp_o(esp),
        .cs_o(cs), .eip_o(eip), .cpl_o(cpl)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    // Registered memory model: read data one cycle after the read.
    always @(posedge clk) if (req && !we) rdata <= pat(addr);

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic add(input logic w, input logic [15:0] s, input logic [31:0] a, input logic [31:0] d);
        e_we[e_n] = w; e_seg[e_n] = s; e_addr[e_n] = a; e_dat[e_n] = d;
        e_n++;
    endtask

    function automatic logic [31:0] fit(input logic [31:0] v);
        return op32 ? v : {16'h0, v[15:0]};
    endfunction

    // Builds the expected traffic of a successful call from the inputs.
    task automatic build_expect();
        logic [31:0] sp, sz, ra;
        int n;
        e_n = 0;
        sz = op32 ? 32'd4 : 32'd2;
        n = int'(wcnt[4:0]);
        if (raise) begin
            sp = nesp;
            sp -= sz; add(1'b1, nss, sp, {16'h0, oss});
            sp -= sz; add(1'b1, nss, sp, fit(oesp));
            for (int i = 0; i < n; i++) begin
                ra = oesp + 32'(n - 1 - i) * sz;
                add(1'b0, oss, ra, 32'h0);
                sp -= sz; add(1'b1, nss, sp, fit(pat(ra)));
            end
        end else sp = oesp;
        sp -= sz; add(1'b1, raise ? nss : oss, sp, {16'h0, rcs});
        sp -= sz; add(1'b1, raise ? nss : oss, sp, fit(reip));
    endtask

    // Pulses start and logs traffic until an outcome or a local timeout.
    task automatic launch();
        l_n = 0; saw_done = 0; saw_gp = 0; saw_ss = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (req && l_n < 64) begin
                l_we[l_n] = we; l_seg[l_n] = seg; l_addr[l_n] = addr;
                l_dat[l_n] = wdata; l_wide[l_n] = wide; l_n++;
            end
            if (done) begin saw_done = 1; break; end
            if (fgp) begin saw_gp = 1; break; end
            if (fss) begin saw_ss = 1; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic good_call(input string rq);
        logic [1:0] nc;
        build_expect();
        launch();
        check(saw_done, {rq, " done"}, 32'(saw_done), 32'd1);
        check(l_n == e_n, {rq, " request count"}, 32'(l_n), 32'(e_n));
        for (int i = 0; i < e_n && i < l_n; i++) begin
            check(l_we[i] == e_we[i] && l_seg[i] == e_seg[i] && l_addr[i] == e_addr[i],
                  {rq, " access kind/seg/addr"}, l_addr[i], e_addr[i]);
            if (e_we[i]) check(l_dat[i] == e_dat[i], {rq, " write data"}, l_dat[i], e_dat[i]);
            check(l_wide[i] == op32, "R7 access width", 32'(l_wide[i]), 32'(op32));
        end
        nc = raise ? ndpl : exp_cpl;
        exp_cpl = nc;
        check(esp == e_addr[e_n-1], "R10 final ESP", esp, e_addr[e_n-1]);
        check(ss == (raise ? nss : oss), "R10 final SS", 32'(ss), 32'(raise ? nss : oss));
        check(eip == fit(teip), "R10 final EIP", eip, fit(teip));
        check(cs == {tcs[15:2], nc}, "R10 final CS", 32'(cs), 32'({tcs[15:2], nc}));
        check(cpl == nc, "R10 final CPL", 32'(cpl), 32'(nc));
        check(!done, "R10 done lasts one cycle", 32'(done), 32'd0);
    endtask

    task automatic bad_call(input string rq, input bit want_gp);
        logic [31:0] pesp, peip; logic [15:0] pss, pcs; logic [1:0] pcpl;
        pesp = esp; peip = eip; pss = ss; pcs = cs; pcpl = cpl;
        launch();
        check(want_gp ? saw_gp : saw_ss, {rq, " fault flag"}, 32'(want_gp ? saw_gp : saw_ss), 32'd1);
        check(l_n == 0, {rq, " no request"}, 32'(l_n), 32'd0);
        check(!fgp && !fss, "R11 fault lasts one cycle", 32'({fgp, fss}), 32'd0);
        check(esp == pesp && eip == peip && ss == pss && cs == pcs && cpl == pcpl,
              "R11 registers kept", esp, pesp);
    endtask

    task automatic base_setup();
        oss = 16'h002B; oesp = 32'h0000_0800; oflr = 32'h0000_0100;
        nss = 16'h0010; nesp = 32'h0000_2000; nflr = 32'h0000_1000; ndpl = 2'd0;
        tcs = 16'h0019; teip = 32'h0000_4321; clim = 32'h0000_FFFF;
        rcs = 16'h0023; reip = 32'h1234_5678;
    endtask

    task automatic t_reset();
        check(ss == 0 && esp == 0 && cs == 0 && eip == 0, "R1 regs zero", esp, 32'd0);
        check(cpl == 2'd3, "R1 CPL reset", 32'(cpl), 32'd3);
        check(!req && !done && !fgp && !fss, "R1 idle outputs", 32'({req, done, fgp, fss}), 32'd0);
    endtask

    task automatic t_raise32();
        base_setup(); raise = 1; op32 = 1; wcnt = 8'd3;
        good_call("R5 R6 R7 raise 32-bit");
    endtask

    task automatic t_raise16_mask();
        base_setup(); raise = 1; op32 = 0; wcnt = 8'hE5; ndpl = 2'd1;
        good_call("R2 R4 raise 16-bit masked count");
        nesp = nflr + 32'd2 * 5 + 32'd7;
        bad_call("R4 16-bit room short by one", 1'b0);
    endtask

    task automatic t_room32();
        base_setup(); raise = 1; op32 = 1; wcnt = 8'd4;
        nesp = nflr + 32'd16 + 32'd16;
        good_call("R3 exact room 32-bit");
        nesp = nflr + 32'd31;
        bad_call("R3 room short by one", 1'b0);
    endtask

    task automatic t_zero_params();
        base_setup(); raise = 1; op32 = 1; wcnt = 8'd0; ndpl = 2'd2;
        good_call("R5 raise no parameters");
    endtask

    task automatic t_same();
        base_setup(); raise = 0; op32 = 1; wcnt = 8'd31; oesp = oflr + 32'd8;
        good_call("R8 same privilege 32-bit exact room");
        base_setup(); raise = 0; op32 = 0; wcnt = 8'd9;
        good_call("R8 same privilege 16-bit");
        oesp = oflr + 32'd3;
        bad_call("R8 same privilege short", 1'b0);
    endtask

    task automatic t_limit();
        base_setup(); raise = 1; op32 = 1; wcnt = 8'd2;
        clim = 32'h0000_4000; nesp = nflr;
        bad_call("R9 limit fault over room fault", 1'b1);
        base_setup(); raise = 0; op32 = 0; wcnt = 8'd0;
        teip = 32'hABCD_0040; clim = 32'h0000_0040;
        good_call("R9 16-bit uses low half");
        teip = 32'h0000_0041;
        bad_call("R9 16-bit over limit", 1'b1);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_raise32();
        t_raise16_mask();
        t_room32();
        t_zero_params();
        t_same();
        t_limit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule